// File: doc/BRIEF.md
# Three-Wire Addressed Register Loader

This block is a serial slave that receives configuration words over three wires: a serial clock, a serial data line and a latch-enable strobe. All three pins are brought into the system clock domain through two-flop synchronizers. Edges are then found on the synchronized levels. Each rising edge of the serial clock shifts one data bit into a 24-bit shift register, most significant bit first.

A rising edge of latch enable ends the frame. If exactly 24 bits were shifted, the two bits shifted last act as an address. The block copies the whole word into one of three destination registers and raises that register's update pulse for one system-clock cycle. These registers are the control word, the reference-divider word and the feedback-divider word. A frame of any other length sets a framing-error flag and writes nothing. The reserved address code writes nothing and raises no error.

Top module: `three_wire_loader`

## Requirements
- R1: A 24-bit frame is stored with its first shifted bit as bit 23 and its last as bit 0; the destination register then holds exactly the shifted word.
- R2: A valid frame whose bits [1:0] equal 2'b00 writes the control-word output and pulses its update strobe.
- R3: A valid frame whose bits [1:0] equal 2'b01 writes the reference-divider output and pulses its update strobe.
- R4: A valid frame whose bits [1:0] equal 2'b10 writes the feedback-divider output and pulses its update strobe.
- R5: A valid frame whose bits [1:0] equal 2'b11 changes no output word, raises no update strobe and leaves the error flag clear.
- R6: A latch-enable strobe after a bit count other than 24 sets the framing-error flag and writes no register. The flag is re-evaluated on every strobe, so the next 24-bit frame clears it.
- R7: An update strobe is high for exactly one system-clock cycle. At most one strobe is high at a time. It appears in the third system-clock cycle after latch enable rises at the pin.
- R8: Synchronous reset clears all three words, all strobes and the error flag.
- R9: Only a rising edge of the serial clock captures data. Data changes while the serial clock is high or low are not captured.
- R10: Each latch-enable strobe restarts the bit count, so consecutive frames are independent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, faster than the serial pins |
| rst | input | 1 | Synchronous active-high reset |
| sclk_i | input | 1 | Serial clock pin, asynchronous |
| sdata_i | input | 1 | Serial data pin, asynchronous |
| sle_i | input | 1 | Latch-enable pin, asynchronous |
| ctrl_word_o | output | 24 | Control-word register |
| ctrl_upd_o | output | 1 | One-cycle pulse when the control word is written |
| rdiv_word_o | output | 24 | Reference-divider register |
| rdiv_upd_o | output | 1 | One-cycle pulse when the reference-divider word is written |
| ndiv_word_o | output | 24 | Feedback-divider register |
| ndiv_upd_o | output | 1 | One-cycle pulse when the feedback-divider word is written |
| frame_err_o | output | 1 | Set when the most recent strobe followed a wrong bit count |

## Verification
The pin-timing properties assume the pins respect the serial timing limits, expressed in system-clock cycles. Data must be steady for at least one system-clock edge before a serial-clock rise. Serial-clock high and low phases must each last at least two system clocks. Latch enable must rise at least one system clock after the last serial-clock fall. The stimulus holds each phase for several system-clock cycles and sets data while the clock is low. It flips data only in the middle of the high phase, which tests R9 and still keeps within these limits.

// File: rtl/tw_pkg.sv
package tw_pkg;
    localparam int WORD_W      = 24;
    localparam int ADDR_W      = 2;
    localparam int NUM_DEST    = 3;
    localparam int SYNC_STAGES = 2;
    localparam int CNT_W       = $clog2(WORD_W + 2);

    typedef enum logic [ADDR_W-1:0] {
        DEST_CTRL = 2'b00,
        DEST_RDIV = 2'b01,
        DEST_NDIV = 2'b10,
        DEST_RSVD = 2'b11
    } dest_e;

    typedef struct packed {
        logic [WORD_W-1:0] word;
        logic              commit;
        logic              bad_len;
    } frame_t;

    function automatic logic is_rise(input logic cur, input logic prev);
        return cur & ~prev;
    endfunction

    function automatic dest_e dest_of(input logic [WORD_W-1:0] w);
        return dest_e'(w[ADDR_W-1:0]);
    endfunction
endpackage

// File: rtl/tw_pin_sync.sv
module tw_pin_sync #(
    parameter int N      = 3,
    parameter int STAGES = tw_pkg::SYNC_STAGES
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] din,
    output logic [N-1:0] lvl
);
    for (genvar b = 0; b < N; b++) begin : g_bit
        logic [STAGES-1:0] pipe;
        always_ff @(posedge clk) begin
            if (rst) pipe <= '0;
            else     pipe <= {pipe[STAGES-2:0], din[b]};
        end
        assign lvl[b] = pipe[STAGES-1];
    end
endmodule

// File: rtl/tw_shifter.sv
module tw_shifter
    import tw_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   sclk_lvl,
    input  logic   sdata_lvl,
    input  logic   le_lvl,
    output frame_t frame
);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(WORD_W);

    logic [WORD_W-1:0] shreg;
    logic [CNT_W-1:0]  cnt;
    logic              sclk_prev, le_prev;
    logic              sclk_rise, le_rise;

    assign sclk_rise = is_rise(sclk_lvl, sclk_prev);
    assign le_rise   = is_rise(le_lvl, le_prev);

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg     <= '0;
            cnt       <= '0;
            sclk_prev <= 1'b0;
            le_prev   <= 1'b0;
        end else begin
            sclk_prev <= sclk_lvl;
            le_prev   <= le_lvl;
            if (le_rise) begin
                cnt <= '0;
            end else if (sclk_rise) begin
                shreg <= {shreg[WORD_W-2:0], sdata_lvl};
                if (cnt != '1) cnt <= cnt + 1'b1;
            end
        end
    end

    always_comb begin
        frame.word    = shreg;
        frame.commit  = le_rise;
        frame.bad_len = (cnt != FULL);
    end
endmodule

// File: rtl/tw_latch_bank.sv
module tw_latch_bank
    import tw_pkg::*;
(
    input  logic                             clk,
    input  logic                             rst,
    input  frame_t                           frame,
    output logic [NUM_DEST-1:0][WORD_W-1:0]  words,
    output logic [NUM_DEST-1:0]              upd,
    output logic                             err
);
    dest_e dsel;
    logic  good;

    assign dsel = dest_of(frame.word);
    assign good = frame.commit & ~frame.bad_len;

    for (genvar g = 0; g < NUM_DEST; g++) begin : g_dest
        logic hit;
        assign hit = good && (dsel == dest_e'(g));
        always_ff @(posedge clk) begin
            if (rst) begin
                words[g] <= '0;
                upd[g]   <= 1'b0;
            end else begin
                upd[g] <= hit;
                if (hit) words[g] <= frame.word;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)               err <= 1'b0;
        else if (frame.commit) err <= frame.bad_len;
    end
endmodule

// File: rtl/three_wire_loader.sv
module three_wire_loader
    import tw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sclk_i,
    input  logic              sdata_i,
    input  logic              sle_i,
    output logic [WORD_W-1:0] ctrl_word_o,
    output logic              ctrl_upd_o,
    output logic [WORD_W-1:0] rdiv_word_o,
    output logic              rdiv_upd_o,
    output logic [WORD_W-1:0] ndiv_word_o,
    output logic              ndiv_upd_o,
    output logic              frame_err_o
);
    logic [2:0]                        pin_lvl;
    frame_t                            frame;
    logic [NUM_DEST-1:0][WORD_W-1:0]   words;
    logic [NUM_DEST-1:0]               upd;

    tw_pin_sync #(.N(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .din ({sle_i, sdata_i, sclk_i}),
        .lvl (pin_lvl)
    );

    tw_shifter u_shift (
        .clk       (clk),
        .rst       (rst),
        .sclk_lvl  (pin_lvl[0]),
        .sdata_lvl (pin_lvl[1]),
        .le_lvl    (pin_lvl[2]),
        .frame     (frame)
    );

    tw_latch_bank u_bank (
        .clk   (clk),
        .rst   (rst),
        .frame (frame),
        .words (words),
        .upd   (upd),
        .err   (frame_err_o)
    );

    assign ctrl_word_o = words[DEST_CTRL];
    assign rdiv_word_o = words[DEST_RDIV];
    assign ndiv_word_o = words[DEST_NDIV];
    assign ctrl_upd_o  = upd[DEST_CTRL];
    assign rdiv_upd_o  = upd[DEST_RDIV];
    assign ndiv_upd_o  = upd[DEST_NDIV];
endmodule

// File: rtl/three_wire_loader_chk.sv
module three_wire_loader_chk
    import tw_pkg::*;
#(
    parameter int MIN_PHASE = 2,
    parameter int MIN_SETUP = 1,
    parameter int MIN_GAP   = 1
) (
    input logic              clk,
    input logic              rst,
    input logic              sclk_i,
    input logic              sdata_i,
    input logic              sle_i,
    input logic [WORD_W-1:0] ctrl_word_o,
    input logic              ctrl_upd_o,
    input logic [WORD_W-1:0] rdiv_word_o,
    input logic              rdiv_upd_o,
    input logic [WORD_W-1:0] ndiv_word_o,
    input logic              ndiv_upd_o,
    input logic              frame_err_o
);
    logic [7:0] phase_cnt, data_age, fall_age;
    logic       sclk_q, sdata_q, sle_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_cnt <= '0;
            data_age  <= '0;
            fall_age  <= '0;
            sclk_q    <= 1'b0;
            sdata_q   <= 1'b0;
            sle_q     <= 1'b0;
        end else begin
            sclk_q  <= sclk_i;
            sdata_q <= sdata_i;
            sle_q   <= sle_i;
            if (sclk_i != sclk_q)            phase_cnt <= '0;
            else if (phase_cnt != 8'hFF)     phase_cnt <= phase_cnt + 1'b1;
            if (sdata_i != sdata_q)          data_age  <= '0;
            else if (data_age != 8'hFF)      data_age  <= data_age + 1'b1;
            if (!sclk_i && sclk_q)           fall_age  <= '0;
            else if (fall_age != 8'hFF)      fall_age  <= fall_age + 1'b1;
        end
    end

    // R7: at most one update strobe at a time
    a_r7_one_strobe: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ctrl_upd_o, rdiv_upd_o, ndiv_upd_o}));

    // R7: strobes last a single cycle
    a_r7_single_cycle: assert property (@(posedge clk) disable iff (rst)
        (ctrl_upd_o || rdiv_upd_o || ndiv_upd_o) |=>
        !(ctrl_upd_o || rdiv_upd_o || ndiv_upd_o));

    // R6: a rising error flag comes with no write
    a_r6_err_no_write: assert property (@(posedge clk) disable iff (rst)
        $rose(frame_err_o) |-> !(ctrl_upd_o || rdiv_upd_o || ndiv_upd_o));

    // R5: words only change together with their own strobe
    a_r5_ctrl_hold: assert property (@(posedge clk) disable iff (rst)
        !ctrl_upd_o |-> $stable(ctrl_word_o));
    a_r5_rdiv_hold: assert property (@(posedge clk) disable iff (rst)
        !rdiv_upd_o |-> $stable(rdiv_word_o));
    a_r5_ndiv_hold: assert property (@(posedge clk) disable iff (rst)
        !ndiv_upd_o |-> $stable(ndiv_word_o));

    // R8: reset clears everything
    a_r8_reset_clear: assert property (@(posedge clk)
        rst |=> (ctrl_word_o == '0 && rdiv_word_o == '0 && ndiv_word_o == '0
                 && !ctrl_upd_o && !rdiv_upd_o && !ndiv_upd_o && !frame_err_o));

    // R9: input assumptions on pin timing, in system-clock cycles
    a_r9_phase_width: assert property (@(posedge clk) disable iff (rst)
        (sclk_i != sclk_q) |-> (phase_cnt >= 8'(MIN_PHASE - 1)));
    a_r9_data_setup: assert property (@(posedge clk) disable iff (rst)
        (sclk_i && !sclk_q) |-> (data_age >= 8'(MIN_SETUP)));
    a_r9_le_gap: assert property (@(posedge clk) disable iff (rst)
        (sle_i && !sle_q) |-> (fall_age >= 8'(MIN_GAP)));
endmodule

bind three_wire_loader three_wire_loader_chk u_chk (.*);

// File: tb/tb_three_wire_loader.sv
module tb_three_wire_loader;
    localparam time CLK_PERIOD = 10ns;
    localparam int  NVEC = 7;
    localparam logic [23:0] VEC [NVEC] = '{
        24'hA5C3F0, 24'h12345D, 24'hFEDCBA, 24'h0F0F0F,
        24'h800001, 24'h555556, 24'hC0FFEC
    };

    logic clk = 1'b0, rst = 1'b1;
    logic sclk_i = 1'b0, sdata_i = 1'b0, sle_i = 1'b0;
    logic [23:0] ctrl_word_o, rdiv_word_o, ndiv_word_o;
    logic ctrl_upd_o, rdiv_upd_o, ndiv_upd_o, frame_err_o;

    int n_chk = 0, n_bad = 0;
    logic [23:0] e_ctrl = '0, e_rdiv = '0, e_ndiv = '0;
    logic [2:0]  snap_upd, next_upd;
    logic        snap_err;

    always #(CLK_PERIOD/2) clk = ~clk;

    three_wire_loader dut (.*);

    task automatic chk(input string req, input logic [23:0] act, input logic [23:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    // shift nbits MSB first from w; extra bits past 24 are zero
    task automatic shift_bits(input logic [23:0] w, input int nbits);
        for (int i = 0; i < nbits; i++) begin
            sdata_i = (i < 24) ? w[23 - i] : 1'b0;
            wait_n(2);
            sclk_i = 1'b1;
            wait_n(2);
            sdata_i = ~sdata_i;   // R9: change while high must not be captured
            wait_n(2);
            sclk_i = 1'b0;
            wait_n(1);
        end
        wait_n(2);
    endtask

    task automatic strobe();
        sle_i = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        snap_upd = {ndiv_upd_o, rdiv_upd_o, ctrl_upd_o};
        snap_err = frame_err_o;
        @(negedge clk);
        next_upd = {ndiv_upd_o, rdiv_upd_o, ctrl_upd_o};
        wait_n(2);
        sle_i = 1'b0;
        wait_n(4);
    endtask

    task automatic check_state(input string req, input logic [2:0] exp_upd, input logic exp_err);
        chk({req, " strobe"}, 24'(snap_upd), 24'(exp_upd));
        chk("R7 strobe one cycle", 24'(next_upd), 24'h0);
        chk({req, " err"}, 24'(snap_err), 24'(exp_err));
        chk({req, " ctrl"}, ctrl_word_o, e_ctrl);
        chk({req, " rdiv"}, rdiv_word_o, e_rdiv);
        chk({req, " ndiv"}, ndiv_word_o, e_ndiv);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        wait_n(5);
        rst = 1'b0;
        wait_n(2);
        // R8: reset state
        chk("R8 ctrl", ctrl_word_o, 24'h0);
        chk("R8 rdiv", rdiv_word_o, 24'h0);
        chk("R8 ndiv", ndiv_word_o, 24'h0);
        chk("R8 flags", {20'h0, ctrl_upd_o, rdiv_upd_o, ndiv_upd_o, frame_err_o}, 24'h0);

        // table walk: R1 R2 R3 R4 R5 R10
        for (int v = 0; v < NVEC; v++) begin
            logic [2:0] eu;
            eu = 3'b000;
            case (VEC[v][1:0])
                2'b00: begin e_ctrl = VEC[v]; eu = 3'b001; end
                2'b01: begin e_rdiv = VEC[v]; eu = 3'b010; end
                2'b10: begin e_ndiv = VEC[v]; eu = 3'b100; end
                default: eu = 3'b000;
            endcase
            shift_bits(VEC[v], 24);
            strobe();
            check_state(VEC[v][1:0] == 2'b00 ? "R2" : VEC[v][1:0] == 2'b01 ? "R3" :
                        VEC[v][1:0] == 2'b10 ? "R4" : "R5", eu, 1'b0);
        end

        // R6: short frame
        shift_bits(24'hFFFFFC, 23);
        strobe();
        check_state("R6 short", 3'b000, 1'b1);
        // R6: long frame
        shift_bits(24'h000001, 25);
        strobe();
        check_state("R6 long", 3'b000, 1'b1);
        // R6: strobe with no bits
        strobe();
        check_state("R6 empty", 3'b000, 1'b1);
        // R10 R6: good frame after errors clears flag
        e_rdiv = 24'h3C3C3D;
        shift_bits(24'h3C3C3D, 24);
        strobe();
        check_state("R10 recover", 3'b010, 1'b0);
        // R1: all-ones word into control address bits 00
        e_ctrl = 24'hFFFFFC;
        shift_bits(24'hFFFFFC, 24);
        strobe();
        check_state("R1 ones", 3'b001, 1'b0);

        // R8: reset mid-run clears loaded words
        rst = 1'b1;
        wait_n(2);
        rst = 1'b0;
        wait_n(1);
        chk("R8 rerun ctrl", ctrl_word_o, 24'h0);
        chk("R8 rerun rdiv", rdiv_word_o, 24'h0);
        chk("R8 rerun ndiv", ndiv_word_o, 24'h0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule